// File: doc/BRIEF.md
# Job Slot Interrupt Status Controller

This block gathers completion and failure events from sixteen job slots into a single 32-bit interrupt word. The lower half carries completions and the upper half carries failures, with one bit per slot in each half. Software reads the raw word, programs an enable mask, and reads the masked view. It acknowledges events by writing ones to a clear register. A single level interrupt line is high while any enabled event is pending.

Every write to the clear register also refreshes a state summary for the slots it touches. That summary holds two bits per slot: one shows that the slot has a running job, and one shows that it has a job waiting behind it. Bits for slots the write did not touch keep their earlier values. Any bus access at or above a window base address skips all of this. It goes out on a slot-register port, tagged with the slot number and the offset inside that slot's 128-byte window. Read data for a window access comes back from that port.

Register offsets (byte addresses): 0x000 raw (read-only), 0x004 clear (write-one-to-clear, reads 0), 0x008 mask (read/write), 0x00C masked status (read-only), 0x010 state summary (read-only). The slot window starts at 0x800. Read data is combinational and is zero whenever no read is in progress. Unmapped offsets below the window read as zero.

Top module: `job_irq_ctrl`

## Requirements
- R1: A one-cycle `done_pulse[n]` sets raw bit n, visible on the next cycle.
- R2: A one-cycle `fail_pulse[n]` sets raw bit 16+n, visible on the next cycle.
- R3: A write to offset 0x004 clears every raw bit whose written bit is one and leaves raw bits written as zero unchanged.
- R4: When an event for a bit arrives in the same cycle as a clear of that bit, the bit ends up set.
- R5: The mask at 0x008 reads back what was written, and offset 0x00C reads raw AND mask.
- R6: `irq` is high exactly when raw AND mask is nonzero.
- R7: A write to 0x004 with value V selects slot n when bit n or bit 16+n of V is one. For each selected slot, state bit n takes `slot_active[n]` and state bit 16+n takes `slot_queued[n]` as sampled in that cycle.
- R8: State bits of slots that are not selected, and all state bits outside clear writes, keep their values whatever the slot levels do.
- R9: An access at address A >= 0x800 raises `slot_req` with `slot_we` equal to the write flag. It presents `slot_sel` = (A-0x800)[10:7], `slot_addr` = (A-0x800)[6:0] and the write data, and returns `slot_rdata` as read data. It changes no interrupt, mask or state bit.
- R10: Synchronous active-low reset clears raw, mask and state to zero, and `irq` reads low.
- R11: Writes to the raw (0x000) and masked status (0x00C) offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| done_pulse | input | 16 | Per-slot completion pulses |
| fail_pulse | input | 16 | Per-slot failure pulses |
| slot_active | input | 16 | Per-slot running-job level |
| slot_queued | input | 16 | Per-slot waiting-job level |
| irq | output | 1 | Level interrupt |
| slot_req | output | 1 | Window access strobe |
| slot_we | output | 1 | Window write flag |
| slot_sel | output | 4 | Selected slot |
| slot_addr | output | 7 | Offset inside slot window |
| slot_wdata | output | 32 | Window write data |
| slot_rdata | input | 32 | Window read data |

## Verification
The bench targets an event and a clear that land on the same bit in the same cycle. A design that lets the clear win would drop an event there. It also sends clears that name a slot only through its failure half. A design that forms the slot set from the low half alone would leave that slot's state stale. Slot levels are toggled without any clear write, which catches a design whose state follows the levels live. Window accesses are mixed with data that would hit the mask and clear registers, which exposes decode that lets a window access leak into the interrupt registers.

// File: rtl/job_irq_pkg.sv
// Shared constants for the job slot interrupt controller.
// Assumes byte addressing with 32-bit registers.
package job_irq_pkg;
    localparam logic [11:0] OFF_RAW   = 12'h000;
    localparam logic [11:0] OFF_CLEAR = 12'h004;
    localparam logic [11:0] OFF_MASK  = 12'h008;
    localparam logic [11:0] OFF_STAT  = 12'h00C;
    localparam logic [11:0] OFF_STATE = 12'h010;

    typedef struct packed {
        logic raw;
        logic clr;
        logic msk;
        logic stat;
        logic state;
        logic win;
    } hit_t;
endpackage

// File: rtl/job_irq_decode.sv
// Address decoder: picks one interrupt register or the slot window.
// Assumes all register offsets lie below WIN_BASE.
module job_irq_decode
    import job_irq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int SPAN_LG = 7,
    parameter int SEL_W   = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [SEL_W-1:0]  sel,
    output logic [SPAN_LG-1:0] off
);
    logic [ADDR_W-1:0] rel;
    logic              above;

    // Purpose: split the address into window or register targets.
    always_comb begin
        rel       = addr - WIN_BASE;
        above     = (addr >= WIN_BASE);
        hit.win   = req && above;
        hit.raw   = req && !above && (addr == ADDR_W'(OFF_RAW));
        hit.clr   = req && !above && (addr == ADDR_W'(OFF_CLEAR));
        hit.msk   = req && !above && (addr == ADDR_W'(OFF_MASK));
        hit.stat  = req && !above && (addr == ADDR_W'(OFF_STAT));
        hit.state = req && !above && (addr == ADDR_W'(OFF_STATE));
        sel       = rel[SPAN_LG +: SEL_W];
        off       = rel[SPAN_LG-1:0];
    end

    // Purpose: at most one target per access.
    always_comb begin
        assert_one_target_R9: assert ($onehot0(hit));
    end
endmodule

// File: rtl/job_irq_raw.sv
// Raw interrupt word: events set bits, clear writes drop them.
// Assumes events win over a clear of the same bit in one cycle.
module job_irq_raw #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] raw_q
);
    logic [W-1:0] drop;

    // Purpose: bits to remove this cycle.
    always_comb drop = clr_en ? clr_bits : '0;

    // Purpose: hold, clear and set the raw word.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~drop) | ev;
    end

    assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((raw_q & $past(ev)) == $past(ev)));

    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((raw_q & $past(clr_bits & ~ev)) == '0));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_q & ~$past(raw_q) & ~$past(ev)) == '0));
endmodule

// File: rtl/job_irq_state.sv
// Two-bit-per-slot state summary, resampled only for selected slots.
// Assumes bit n = running job, bit N+n = waiting job.
module job_irq_state #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd_en,
    input  logic [N-1:0]   pick,
    input  logic [N-1:0]   act,
    input  logic [N-1:0]   que,
    output logic [2*N-1:0] state_q
);
    logic [2*N-1:0] upd_mask;

    // Purpose: widen the slot set to both halves.
    always_comb upd_mask = upd_en ? {pick, pick} : '0;

    for (genvar n = 0; n < N; n++) begin : g_slot
        // Purpose: resample one slot's running and waiting bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[n]   <= 1'b0;
                state_q[N+n] <= 1'b0;
            end else if (upd_en && pick[n]) begin
                state_q[n]   <= act[n];
                state_q[N+n] <= que[n];
            end
        end
    end

    assert_resample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (((state_q ^ {$past(que), $past(act)}) & $past({pick, pick})) == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((state_q ^ $past(state_q)) & ~$past(upd_mask)) == '0));
endmodule

// File: rtl/job_irq_ctrl.sv
// Job slot interrupt controller top: register file, irq line, slot routing.
// Assumes a single-cycle bus with combinational read data.
module job_irq_ctrl
    import job_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int ADDR_W    = 12,
    parameter int SPAN_LG   = 7,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int DW       = 2 * NUM_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_SLOTS-1:0] done_pulse,
    input  logic [NUM_SLOTS-1:0] fail_pulse,
    input  logic [NUM_SLOTS-1:0] slot_active,
    input  logic [NUM_SLOTS-1:0] slot_queued,
    output logic                 irq,
    output logic                 slot_req,
    output logic                 slot_we,
    output logic [SEL_W-1:0]     slot_sel,
    output logic [SPAN_LG-1:0]   slot_addr,
    output logic [DW-1:0]        slot_wdata,
    input  logic [DW-1:0]        slot_rdata
);
    hit_t                 hit;
    logic [DW-1:0]        raw_q;
    logic [DW-1:0]        mask_q;
    logic [DW-1:0]        state_q;
    logic [DW-1:0]        masked;
    logic                 clr_wr;
    logic [NUM_SLOTS-1:0] pick;

    job_irq_decode #(
        .ADDR_W(ADDR_W), .SPAN_LG(SPAN_LG), .SEL_W(SEL_W), .WIN_BASE(WIN_BASE)
    ) u_dec (
        .req(bus_req), .addr(bus_addr), .hit(hit), .sel(slot_sel), .off(slot_addr)
    );

    // Purpose: clear-write strobe and the slot set it names.
    always_comb begin
        clr_wr = hit.clr && bus_we;
        pick   = bus_wdata[NUM_SLOTS-1:0] | bus_wdata[DW-1:NUM_SLOTS];
    end

    job_irq_raw #(.W(DW)) u_raw (
        .clk(clk), .rst_n(rst_n), .ev({fail_pulse, done_pulse}),
        .clr_en(clr_wr), .clr_bits(bus_wdata), .raw_q(raw_q)
    );

    job_irq_state #(.N(NUM_SLOTS)) u_state (
        .clk(clk), .rst_n(rst_n), .upd_en(clr_wr), .pick(pick),
        .act(slot_active), .que(slot_queued), .state_q(state_q)
    );

    // Purpose: software-owned enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mask_q <= '0;
        else if (hit.msk && bus_we)   mask_q <= bus_wdata;
    end

    // Purpose: masked view, interrupt line and window port.
    always_comb begin
        masked     = raw_q & mask_q;
        irq        = |masked;
        slot_req   = hit.win;
        slot_we    = hit.win && bus_we;
        slot_wdata = bus_wdata;
    end

    // Purpose: read data mux, zero outside reads.
    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            if (hit.win)        bus_rdata = slot_rdata;
            else if (hit.raw)   bus_rdata = raw_q;
            else if (hit.msk)   bus_rdata = mask_q;
            else if (hit.stat)  bus_rdata = masked;
            else if (hit.state) bus_rdata = state_q;
        end
    end

    assert_irq_needs_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_q != '0 && mask_q != '0));

    assert_window_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |=> $stable(mask_q));

    assert_window_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |=> $stable(state_q));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0 && state_q == '0));
endmodule

// File: tb/tb_job_irq_ctrl.sv
module tb_job_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [15:0] done_pulse = '0, fail_pulse = '0, slot_active = '0, slot_queued = '0;
    logic        irq, slot_req, slot_we;
    logic [3:0]  slot_sel;
    logic [6:0]  slot_addr;
    logic [31:0] slot_wdata, slot_rdata = '0;

    int n_tests = 0, n_fail = 0;
    logic [31:0] m_raw = '0, m_mask = '0, m_state = '0;

    always #5 clk = ~clk;

    job_irq_ctrl dut (.*);

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        if (!bus_req || bus_we) return '0;
        if (bus_addr >= 12'h800) return slot_rdata;
        case (bus_addr)
            12'h000: return m_raw;
            12'h008: return m_mask;
            12'h00C: return m_raw & m_mask;
            12'h010: return m_state;
            default: return '0;
        endcase
    endfunction

    // Compare outputs for the inputs now applied, advance the model, move to next negedge.
    task automatic cyc(string tag);
        logic        win, clr;
        logic [15:0] pk;
        logic [11:0] rel;
        #1;
        win = bus_req && (bus_addr >= 12'h800);
        rel = bus_addr - 12'h800;
        if (rst_n) begin
            chk(tag, "rdata", bus_rdata, exp_rd());
            chk("R6", "irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            chk("R9", "slot_req", {31'd0, slot_req}, {31'd0, win});
            chk("R9", "slot_we", {31'd0, slot_we}, {31'd0, win && bus_we});
            if (win) begin
                chk("R9", "slot_sel", {28'd0, slot_sel}, {28'd0, rel[10:7]});
                chk("R9", "slot_addr", {25'd0, slot_addr}, {25'd0, rel[6:0]});
                chk("R9", "slot_wdata", slot_wdata, bus_wdata);
            end
        end
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_state = '0;
        end else begin
            clr = bus_req && bus_we && !win && bus_addr == 12'h004;
            if (clr) begin
                pk = bus_wdata[15:0] | bus_wdata[31:16];
                for (int i = 0; i < 16; i++)
                    if (pk[i]) begin
                        m_state[i]    = slot_active[i];
                        m_state[16+i] = slot_queued[i];
                    end
                m_raw = m_raw & ~bus_wdata;
            end
            m_raw = m_raw | {fail_pulse, done_pulse};
            if (bus_req && bus_we && !win && bus_addr == 12'h008) m_mask = bus_wdata;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        bus_req = 0; bus_we = 0; done_pulse = '0; fail_pulse = '0;
    endtask

    task automatic acc(logic we, logic [11:0] a, logic [31:0] d, string tag);
        bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        cyc(tag);
        idle();
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R10: events and a mask write during reset must be lost
        done_pulse = 16'hFFFF; fail_pulse = 16'hFFFF; slot_active = 16'hFFFF;
        bus_req = 1; bus_we = 1; bus_addr = 12'h008; bus_wdata = '1;
        for (int i = 0; i < 3; i++) cyc("R10");
        idle(); rst_n = 1;
        bus_req = 1; bus_we = 0; bus_addr = 12'h000;
        #1; chk("R10", "raw after reset", bus_rdata, 32'h0);
        chk("R10", "irq after reset", {31'd0, irq}, 32'h0);
        cyc("R10");
        acc(0, 12'h008, 0, "R10");
        acc(0, 12'h010, 0, "R10");

        // R1 and R2: single events
        done_pulse = 16'h0008; cyc("R1"); idle();
        acc(0, 12'h000, 0, "R1");
        fail_pulse = 16'h0200; cyc("R2"); idle();
        acc(0, 12'h000, 0, "R2");

        // R11: writes to raw and status are ignored
        acc(1, 12'h000, 32'hFFFF_FFFF, "R11");
        acc(0, 12'h000, 0, "R11");
        acc(1, 12'h00C, 32'h0000_0000, "R11");
        acc(0, 12'h000, 0, "R11");

        // R5 and R6: mask and masked view
        acc(1, 12'h008, 32'h0200_0000, "R5");
        acc(0, 12'h008, 0, "R5");
        acc(0, 12'h00C, 0, "R5");
        acc(1, 12'h008, 32'h0200_0008, "R6");
        acc(0, 12'h00C, 0, "R6");

        // R3: clear one bit, leave the other
        acc(1, 12'h004, 32'h0000_0008, "R3");
        acc(0, 12'h000, 0, "R3");

        // R4: event and clear of the same bit together
        done_pulse = 16'h0020;
        acc(1, 12'h004, 32'h0000_0020, "R4");
        acc(0, 12'h000, 0, "R4");

        // R7: slots named through the failure half and the done half
        slot_active = 16'h0005; slot_queued = 16'h0006;
        acc(1, 12'h004, 32'h0001_0002, "R7");
        acc(0, 12'h010, 0, "R7");

        // R8: levels move without a clear; then a clear of another slot
        slot_active = 16'h0000; slot_queued = 16'hFFFF;
        cyc("R8"); cyc("R8");
        acc(0, 12'h010, 0, "R8");
        acc(1, 12'h004, 32'h0000_0004, "R8");
        acc(0, 12'h010, 0, "R8");

        // R9: window accesses at addresses that alias register offsets
        slot_rdata = 32'hCAFE_0123;
        acc(1, 12'h808, 32'hFFFF_FFFF, "R9");
        acc(1, 12'h804, 32'hFFFF_FFFF, "R9");
        acc(0, 12'hFFC, 0, "R9");
        acc(0, 12'h008, 0, "R9");
        acc(0, 12'h010, 0, "R9");

        // Mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] s;
            s = 3'($urandom_range(0, 7));
            bus_req = ($urandom_range(0, 3) != 0);
            bus_we = 1'($urandom);
            bus_addr = (s == 7) ? 12'($urandom_range(12'h800, 12'hFFF))
                                : 12'(s * 4);
            bus_wdata = $urandom;
            done_pulse = 16'($urandom) & 16'($urandom) & 16'($urandom);
            fail_pulse = 16'($urandom) & 16'($urandom) & 16'($urandom);
            slot_active = 16'($urandom);
            slot_queued = 16'($urandom);
            slot_rdata = $urandom;
            cyc("R5");
        end
        idle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule